// File: doc/BRIEF.md
# Monotonic-Switching SAR Conversion Controller

This block sequences one conversion of a 10-bit differential charge-redistribution successive-approximation converter whose capacitor array switches monotonically, downward only. A sample input, held high by the surrounding clocking, clears every bit decision and holds both capacitor arrays at the reference level. When sample falls, the controller runs ten comparisons from the most significant bit down. The first comparison is made with nothing switched. After each of the first nine decisions it pulls exactly one capacitor to ground: the positive-side capacitor if the positive input was higher, otherwise the negative-side capacitor of the same weight.

The comparator is strobed through an active-high reset strobe (high means reset, low means compare). Each step ends when the comparator raises its valid flag, or when a cycle timeout expires, in which case a 0 decision is forced so a stuck comparator cannot stall the sequence. After every switch update the strobe is held high for a parameterised number of settling cycles before the next comparison. When the tenth bit is decided a one-cycle done pulse is raised and the result holds until the next sample.

Top module: `sar_mono_ctrl`

## Requirements
- R1: With an ideal comparator and the array modelled so that positive-side or negative-side capacitor k (index k-1 on the switch buses, k = 1..9) removes 512>>(k-1) LSB from its side, the 10-bit result (bit 9 = first decision) equals (d+2047)/2-512 for an input difference d = vinp-vinn in LSB within -1023..1024.
- R2: In the cycle after sample is seen high, every switch control is 1 (inactive), result is 0, done is 0 and cmp_strobe is 1, even in the middle of a conversion.
- R3: The first comparison of a conversion happens with all switch controls inactive; a decision of cmp_dec = 1 (positive higher) gives a result bit of 1.
- R4: After a conversion, swp_n[k-1] is 0 exactly when decision k (result bit 10-k) was 1, and swn_n[k-1] is 0 exactly when it was 0, for k = 1..9; between two consecutive cycles at most one control goes low, and no pair swp_n[i], swn_n[i] is ever low together.
- R5: Outside of sample and reset, no switch control ever returns from 0 to 1.
- R6: Every period with cmp_strobe high that ends in a comparison lasts at least SETTLE_CYC cycles, and a switch control only changes while cmp_strobe is high.
- R7: done is high for exactly one cycle after the tenth decision, and result holds its value after done until sample goes high.
- R8: If cmp_valid stays low for TIMEOUT_CYC compare cycles, the decision is taken as 0 and the sequence continues; with a silent comparator the result is 0, every swn_n bit is 0 and every swp_n bit is 1.
- R9: After reset with sample low the block idles: cmp_strobe stays 1, every switch control stays 1 and done stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | High: track input and clear; falling starts a conversion |
| cmp_dec | input | 1 | Comparator decision, 1 when positive input is higher |
| cmp_valid | input | 1 | Comparator has resolved the current comparison |
| cmp_strobe | output | 1 | Comparator control: 1 reset, 0 compare |
| swp_n | output | NBITS-1 | Positive-side capacitor controls, active-low (0 = pulled to ground) |
| swn_n | output | NBITS-1 | Negative-side capacitor controls, active-low (0 = pulled to ground) |
| result | output | NBITS | Conversion result, MSB decided first |
| done | output | 1 | One-cycle pulse after the last decision |

## Verification
The conversion is tried with differences right at the decision threshold (0, 1, 2, -1), at both full-scale ends, and with a pseudo-random spread; the threshold cases separate a strict from a non-strict comparison and an off-by-one in the capacitor weights, while the full-scale cases expose a wrong bit order or a wrong polarity on either side. A silent comparator separates a working timeout from a stalled or wrongly forced decision, and a sample pulse raised mid-conversion shows whether the clear reaches every switch and the result. During every conversion the bench watches the switch buses cycle by cycle for more than one new low, for any release and for too short a settling gap.

// File: rtl/sar_mono_pkg.sv
package sar_mono_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_SAMP = 2'd1,
    ST_SETL = 2'd2,
    ST_CMP  = 2'd3
  } step_e;
endpackage

// File: rtl/sar_bit_slice.sv
// One decision slot: remembers whether its phase has run and which side won.
module sar_bit_slice (
  input  logic clk,
  input  logic clr,
  input  logic load,
  input  logic val,
  output logic en_q,
  output logic dec_q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      en_q  <= 1'b0;
      dec_q <= 1'b0;
    end else if (load) begin
      en_q  <= 1'b1;
      dec_q <= val;
    end
  end
endmodule

// File: rtl/sar_step_seq.sv
// Step sequencer: sample, settle, compare (valid or timeout), repeat.
module sar_step_seq
  import sar_mono_pkg::*;
#(
  parameter int NBITS       = 10,
  parameter int SETTLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 8,
  localparam int IW      = $clog2(NBITS),
  localparam int CNT_MAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC,
  localparam int CW      = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample,
  input  logic          cmp_valid,
  input  logic          cmp_dec,
  output logic          strobe,
  output logic          load,
  output logic [IW-1:0] load_idx,
  output logic          load_val,
  output logic          done
);
  step_e         state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          tmo;

  assign tmo      = (cnt == CW'(TIMEOUT_CYC - 1));
  assign load     = (state == ST_CMP) && !sample && !rst && (cmp_valid || tmo);
  assign load_idx = idx;
  assign load_val = cmp_valid & cmp_dec;
  assign strobe   = (state != ST_CMP);

  always_ff @(posedge clk) begin
    if (rst || sample) begin
      state <= sample ? ST_SAMP : ST_HOLD;
      cnt   <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_SAMP: begin
          state <= ST_SETL;
          cnt   <= '0;
        end
        ST_SETL: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            state <= ST_CMP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CMP: begin
          if (load) begin
            cnt <= '0;
            if (idx == IW'(NBITS - 1)) begin
              state <= ST_HOLD;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_SETL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/sar_mono_ctrl.sv
// Monotonic-switching SAR controller top.
module sar_mono_ctrl #(
  parameter int NBITS       = 10,
  parameter int SETTLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample,
  input  logic             cmp_dec,
  input  logic             cmp_valid,
  output logic             cmp_strobe,
  output logic [NBITS-2:0] swp_n,
  output logic [NBITS-2:0] swn_n,
  output logic [NBITS-1:0] result,
  output logic             done
);
  localparam int NSW = NBITS - 1;
  localparam int IW  = $clog2(NBITS);

  logic             load;
  logic [IW-1:0]    load_idx;
  logic             load_val;
  logic             clr;
  logic [NBITS-1:0] en;
  logic [NBITS-1:0] dec;

  assign clr = rst | sample;

  sar_step_seq #(
    .NBITS      (NBITS),
    .SETTLE_CYC (SETTLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .sample   (sample),
    .cmp_valid(cmp_valid),
    .cmp_dec  (cmp_dec),
    .strobe   (cmp_strobe),
    .load     (load),
    .load_idx (load_idx),
    .load_val (load_val),
    .done     (done)
  );

  // Slot g holds decision g+1 (g = 0 is the most significant).
  for (genvar g = 0; g < NBITS; g++) begin : g_slot
    sar_bit_slice u_slice (
      .clk  (clk),
      .clr  (clr),
      .load (load && (load_idx == IW'(g))),
      .val  (load_val),
      .en_q (en[g]),
      .dec_q(dec[g])
    );
    assign result[NBITS-1-g] = en[g] & dec[g];
    if (g < NSW) begin : g_sw
      assign swp_n[g] = ~(en[g] &  dec[g]);
      assign swn_n[g] = ~(en[g] & ~dec[g]);
    end
  end
endmodule

// File: rtl/sar_mono_chk.sv
module sar_mono_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             sample,
  input logic             cmp_strobe,
  input logic [NBITS-2:0] swp_n,
  input logic [NBITS-2:0] swn_n,
  input logic [NBITS-1:0] result,
  input logic             done
);
  assert_clear_on_sample_R2: assert property (@(posedge clk) disable iff (rst)
    sample |=> ((&swp_n) && (&swn_n) && !done && (result == '0) && cmp_strobe));

  assert_single_new_low_R4: assert property (@(posedge clk) disable iff (rst)
    !sample |=> ($countones((~swp_n & $past(swp_n)) | (~swn_n & $past(swn_n))) <= 1));

  assert_pair_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    ((~swp_n & ~swn_n) == '0));

  assert_no_release_R5: assert property (@(posedge clk) disable iff (rst)
    !sample |=> (((swp_n & ~$past(swp_n)) == '0) && ((swn_n & ~$past(swn_n)) == '0)));

  assert_switch_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
    ((swp_n != $past(swp_n)) || (swn_n != $past(swn_n))) |-> cmp_strobe);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !sample) |=> (result == $past(result)));
endmodule

bind sar_mono_ctrl sar_mono_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample    (sample),
  .cmp_strobe(cmp_strobe),
  .swp_n     (swp_n),
  .swn_n     (swn_n),
  .result    (result),
  .done      (done)
);

// File: tb/sar_mono_ctrl_tb.sv
`timescale 1ns/1ps
module sar_mono_ctrl_tb;
  localparam int NB     = 10;
  localparam int NSW    = NB - 1;
  localparam int SETTLE = 2;
  localparam int TMO    = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sample = 1'b0;
  logic           cmp_dec = 1'b0;
  logic           cmp_valid = 1'b0;
  logic           cmp_strobe;
  logic [NSW-1:0] swp_n;
  logic [NSW-1:0] swn_n;
  logic [NB-1:0]  result;
  logic           done;

  int n_chk = 0;
  int n_err = 0;
  int vinp = 0;
  int vinn = 0;
  bit mute = 1'b0;

  always #5 clk = ~clk;

  sar_mono_ctrl #(.NBITS(NB), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .sample(sample), .cmp_dec(cmp_dec),
    .cmp_valid(cmp_valid), .cmp_strobe(cmp_strobe), .swp_n(swp_n),
    .swn_n(swn_n), .result(result), .done(done)
  );

  function automatic int pulled(input logic [NSW-1:0] sw);
    int s = 0;
    for (int k = 0; k < NSW; k++) if (!sw[k]) s += (512 >> k);
    return s;
  endfunction

  function automatic int ideal(input int d);
    int c = (d + 2047) / 2 - 512;
    if (c < 0) c = 0;
    if (c > 1023) c = 1023;
    return c;
  endfunction

  // Behavioural comparator: resolves one half cycle into the compare phase.
  always @(negedge clk) begin
    if (cmp_strobe || mute) begin
      cmp_valid <= 1'b0;
    end else begin
      cmp_valid <= 1'b1;
      cmp_dec   <= ((vinp - pulled(swp_n)) > (vinn - pulled(swn_n)));
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset_idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmp_strobe == 1'b1, "R2", "strobe in reset", cmp_strobe, 1);
    chk((&swp_n) && (&swn_n), "R2", "switches in reset", {swp_n, swn_n}, 18'h3ffff);
    chk(result == '0 && !done, "R2", "result in reset", result, 0);
    rst = 1'b0;
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!cmp_strobe || !(&swp_n) || !(&swn_n) || done) bad = 1'b1;
      end
      chk(!bad, "R9", "idle without sample", bad, 0);
    end
  endtask

  task automatic t_convert(input int p, input int n, input bit mute_i,
                           input int exp_code, input string tag);
    logic [NSW-1:0] pp, pn, nl;
    int  hi_run = 0;
    bit  multi = 0, rel = 0, pair = 0, shortset = 0, first_seen = 0, first_clean = 1;
    bit  got = 0;
    int  held;
    vinp = p; vinn = n; mute = mute_i;
    @(negedge clk) sample = 1'b1;
    repeat (2) @(negedge clk);
    sample = 1'b0;
    pp = swp_n; pn = swn_n;
    for (int i = 0; i < 600 && !got; i++) begin
      @(negedge clk);
      nl = (~swp_n & pp) | (~swn_n & pn);
      if ($countones(nl) > 1) multi = 1;
      if (((swp_n & ~pp) | (swn_n & ~pn)) != '0) rel = 1;
      if ((~swp_n & ~swn_n) != '0) pair = 1;
      if (cmp_strobe) hi_run++;
      else begin
        if (hi_run > 0 && hi_run < SETTLE) shortset = 1;
        if (!first_seen) begin
          first_seen = 1;
          if (!(&swp_n) || !(&swn_n)) first_clean = 0;
        end
        hi_run = 0;
      end
      if (done) got = 1;
      pp = swp_n; pn = swn_n;
    end
    chk(got, "R7", {tag, " done seen"}, got, 1);
    chk(result == exp_code[NB-1:0], mute_i ? "R8" : "R1", {tag, " result"}, result, exp_code);
    for (int k = 0; k < NSW; k++) begin
      bit b = exp_code[NB-1-k];
      chk(swp_n[k] == !b && swn_n[k] == b, mute_i ? "R8" : "R4",
          {tag, " final switch pair"}, {swp_n[k], swn_n[k]}, {!b, b});
    end
    chk(!multi && !pair, "R4", {tag, " one new low per step"}, multi, 0);
    chk(!rel, "R5", {tag, " no release"}, rel, 0);
    chk(!shortset, "R6", {tag, " settle gap"}, shortset, 0);
    chk(first_seen && first_clean, "R3", {tag, " first compare unswitched"}, first_clean, 1);
    held = result;
    @(negedge clk);
    chk(!done, "R7", {tag, " done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    chk(result == held[NB-1:0], "R7", {tag, " result holds"}, result, held);
    mute = 1'b0;
  endtask

  task automatic t_mid_clear();
    vinp = 700; vinn = 100; mute = 1'b0;
    @(negedge clk) sample = 1'b1;
    @(negedge clk) sample = 1'b0;
    repeat (14) @(negedge clk);
    chk(!((&swp_n) && (&swn_n)), "R2", "switching under way before clear", 0, 1);
    sample = 1'b1;
    @(negedge clk);
    chk((&swp_n) && (&swn_n), "R2", "mid clear switches", {swp_n, swn_n}, 18'h3ffff);
    chk(result == '0 && !done && cmp_strobe, "R2", "mid clear result", result, 0);
    sample = 1'b0;
  endtask

  initial begin
    int lf = 32'h1d5a;
    repeat (2) @(negedge clk);
    t_reset_idle();
    t_convert(500, 500, 0, ideal(0),     "diff0");
    t_convert(501, 500, 0, ideal(1),     "diff1");
    t_convert(502, 500, 0, ideal(2),     "diff2");
    t_convert(499, 500, 0, ideal(-1),    "diffm1");
    t_convert(1024, 0,  0, ideal(1024),  "fullpos");
    t_convert(0, 1023,  0, ideal(-1023), "fullneg");
    t_convert(300, 0,   0, ideal(300),   "mid");
    t_convert(0, 0,     1, 0,            "timeout");
    t_mid_clear();
    t_convert(640, 0,   0, ideal(640),   "after_clear");
    for (int r = 0; r < 16; r++) begin
      int d;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hb4bcd35c : 0);
      d = int'(lf[10:0] % 2047) - 1023;
      t_convert(d + 1100, 1100, 0, ideal(d), "random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule